// File: doc/BRIEF.md
# Seven-level stacked-carrier PWM modulator

This block turns a signed sinusoidal reference sample into the switch pattern of a single-phase, seven-level asymmetrical inverter. Six triangular carriers are stacked one above the other, and each one fills a single voltage band between two adjacent output levels. When a sample-valid strobe arrives, the block counts how many carriers lie strictly below the reference. That count, minus three, gives the output level in the range -3 to +3. The level is then decoded into eight gate signals.

All six carriers come from one shared up/down ramp. A two-bit mode input chooses, for each carrier, whether it uses the ramp directly or its mirror (amplitude minus ramp), which is the same waveform shifted by half a period. The three choices are: every carrier in phase; the bands above zero opposite to the bands below zero; or adjacent bands alternating. The level and gate outputs are registered. They change only in the cycle after a strobe.

Top module: `ml_pwm_mod`

## Requirements
- R1: While reset is high, and after it, until the first accepted strobe, `lvl` is 0 and `gate` is 8'b01011010. Bit i of `gate` drives switch i+1.
- R2: `lvl` and `gate` take a new value only at the clock edge where `smp_vld` is high, so they are visible one cycle after the strobe. Without a strobe they hold, whatever happens on `ref_smp` and `car_mode`.
- R3: The ramp t starts at 0 in the first cycle after reset and rises by STEP = 2·AMP/CAR_PERIOD each cycle up to AMP = 2^AMP_LOG2. It then falls by STEP back to 0 and repeats, so the period is CAR_PERIOD cycles.
- R4: Carrier k (k = 0..5, bottom to top) is (k-3)·AMP + u_k, where u_k is t or AMP-t. `lvl` is the number of carriers below the reference, minus 3.
- R5: A reference equal to a carrier value does not count that carrier, so a tie never raises the level.
- R6: With `car_mode` 0 or 3, every carrier uses u_k = t.
- R7: With `car_mode` 1, carriers 3..5 (above zero) use t and carriers 0..2 use AMP-t.
- R8: With `car_mode` 2, odd k uses t and even k uses AMP-t. The band just above zero (k = 3) therefore uses t, and each carrier is opposite to its neighbours.
- R9: The gate pattern written S1..S8 is 00110110 for +3, 01010110 for +2, 00111010 for +1, 01011010 for 0, 00111001 for -1, 01011001 for -2 and 11001001 for -3.
- R10: A reference above 3·AMP always gives +3. A reference at or below -3·AMP always gives -3.
- R11: S5 and S6 are always complementary, and so are S7 and S8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Reference sample strobe |
| ref_smp | input | REF_W (12) | Signed reference; ±3·AMP is full scale |
| car_mode | input | 2 | Carrier phasing: 0/3 in phase, 1 opposite halves, 2 alternating |
| lvl | output | 3 | Signed output level, -3..+3 |
| gate | output | 8 | Switch gates, bit i = switch i+1 |

## Verification
The bench builds the block with CAR_PERIOD = 16 and the default 512-count amplitude. This gives a ramp step of 64, so a full rise and fall takes only sixteen cycles. With these values the bench can place a strobe at any chosen ramp phase, on both the rising and the falling slope. It can also put the reference exactly on a carrier peak or floor, which tests ties and saturation. At a single ramp value the three phasing modes then give different levels, so each mode is told apart at the ports.

// File: rtl/mlp_pkg.sv
package mlp_pkg;

  localparam int NCAR = 6;
  localparam int HALF = NCAR / 2;

  typedef logic signed [2:0] lvl_t;
  typedef logic [7:0]        gate_t;

  typedef enum logic [1:0] {
    MODE_SAME  = 2'd0,
    MODE_SPLIT = 2'd1,
    MODE_ALT   = 2'd2,
    MODE_SAME2 = 2'd3
  } car_mode_e;

  // Decide whether carrier k follows the mirrored ramp.
  function automatic logic car_inv(input logic [1:0] mode, input int k);
    case (mode)
      MODE_SPLIT: return (k < HALF);
      MODE_ALT:   return ((k % 2) == 0);
      default:    return 1'b0;
    endcase
  endfunction

  // Absolute value of carrier k for ramp t.
  function automatic int carrier_at(input int k, input int t, input logic inv,
                                    input int amp);
    int u;
    u = inv ? (amp - t) : t;
    return (k - HALF) * amp + u;
  endfunction

  // Signed level from the set of carriers lying below the reference.
  function automatic lvl_t level_of(input logic [NCAR-1:0] below);
    int n;
    n = 0;
    for (int i = 0; i < NCAR; i++) n += int'(below[i]);
    return lvl_t'(n - HALF);
  endfunction

  // Gate pattern per level; bit i drives switch i+1.
  function automatic gate_t gate_of(input lvl_t lv);
    case (lv)
      3'sd3:  return 8'b0110_1100;
      3'sd2:  return 8'b0110_1010;
      3'sd1:  return 8'b0101_1100;
      -3'sd1: return 8'b1001_1100;
      -3'sd2: return 8'b1001_1010;
      -3'sd3: return 8'b1001_0011;
      default: return 8'b0101_1010;
    endcase
  endfunction

endpackage

// File: rtl/mlp_ramp_gen.sv
module mlp_ramp_gen #(
  parameter int AMP_LOG2   = 9,
  parameter int CAR_PERIOD = 64
) (
  input  logic                clk,
  input  logic                rst,
  output logic [AMP_LOG2:0]   car_ramp
);
  localparam int AMP  = 1 << AMP_LOG2;
  localparam int STEP = (2 * AMP) / CAR_PERIOD;
  localparam int TW   = AMP_LOG2 + 1;

  logic [TW-1:0] ramp_q;
  logic          rising_q;
  logic [TW-1:0] ramp_up;
  logic [TW-1:0] ramp_dn;

  assign ramp_up = ramp_q + TW'(STEP);
  assign ramp_dn = ramp_q - TW'(STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      ramp_q   <= '0;
      rising_q <= 1'b1;
    end else if (rising_q) begin
      ramp_q <= ramp_up;
      if (ramp_up == TW'(AMP)) rising_q <= 1'b0;
    end else begin
      ramp_q <= ramp_dn;
      if (ramp_dn == '0) rising_q <= 1'b1;
    end
  end

  assign car_ramp = ramp_q;
endmodule

// File: rtl/mlp_cmp_bank.sv
module mlp_cmp_bank #(
  parameter int REF_W    = 12,
  parameter int AMP_LOG2 = 9
) (
  input  logic signed [REF_W-1:0]     ref_smp,
  input  logic [1:0]                  car_mode,
  input  logic [AMP_LOG2:0]           car_ramp,
  output logic [mlp_pkg::NCAR-1:0]    below_vec
);
  localparam int AMP = 1 << AMP_LOG2;

  int ref_i;
  int ramp_i;
  assign ref_i  = int'(ref_smp);
  assign ramp_i = int'(car_ramp);

  for (genvar k = 0; k < mlp_pkg::NCAR; k++) begin : g_car
    int car_k;
    assign car_k = mlp_pkg::carrier_at(k, ramp_i,
                                       mlp_pkg::car_inv(car_mode, k), AMP);
    assign below_vec[k] = (ref_i > car_k);
  end
endmodule

// File: rtl/mlp_out_stage.sv
module mlp_out_stage (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       smp_vld,
  input  logic [mlp_pkg::NCAR-1:0]   below_vec,
  output mlp_pkg::lvl_t              lvl,
  output mlp_pkg::gate_t             gate
);
  mlp_pkg::lvl_t lvl_nxt;
  assign lvl_nxt = mlp_pkg::level_of(below_vec);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl  <= '0;
      gate <= mlp_pkg::gate_of(3'sd0);
    end else if (smp_vld) begin
      lvl  <= lvl_nxt;
      gate <= mlp_pkg::gate_of(lvl_nxt);
    end
  end
endmodule

// File: rtl/ml_pwm_mod.sv
module ml_pwm_mod #(
  parameter int REF_W      = 12,
  parameter int AMP_LOG2   = 9,
  parameter int CAR_PERIOD = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_vld,
  input  logic signed [REF_W-1:0] ref_smp,
  input  logic [1:0]              car_mode,
  output logic signed [2:0]       lvl,
  output logic [7:0]              gate
);
  logic [AMP_LOG2:0]          car_ramp;
  logic [mlp_pkg::NCAR-1:0]   below_vec;

  mlp_ramp_gen #(.AMP_LOG2(AMP_LOG2), .CAR_PERIOD(CAR_PERIOD)) u_ramp (
    .clk      (clk),
    .rst      (rst),
    .car_ramp (car_ramp)
  );

  mlp_cmp_bank #(.REF_W(REF_W), .AMP_LOG2(AMP_LOG2)) u_cmp (
    .ref_smp   (ref_smp),
    .car_mode  (car_mode),
    .car_ramp  (car_ramp),
    .below_vec (below_vec)
  );

  mlp_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .smp_vld   (smp_vld),
    .below_vec (below_vec),
    .lvl       (lvl),
    .gate      (gate)
  );
endmodule

// File: rtl/mlp_chk.sv
module mlp_chk #(
  parameter int AMP_LOG2   = 9,
  parameter int CAR_PERIOD = 64
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     smp_vld,
  input logic signed [2:0]        lvl,
  input logic [7:0]               gate,
  input logic [AMP_LOG2:0]        car_ramp,
  input logic [mlp_pkg::NCAR-1:0] below_vec
);
  localparam int AMP  = 1 << AMP_LOG2;
  localparam int STEP = (2 * AMP) / CAR_PERIOD;

  assert_lvl_range_R4: assert property (@(posedge clk) disable iff (rst)
    lvl != -3'sd4);

  assert_leg_pair_R11: assert property (@(posedge clk) disable iff (rst)
    (gate[4] ^ gate[5]) && (gate[6] ^ gate[7]));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(smp_vld)) |-> ($stable(lvl) && $stable(gate)));

  assert_ramp_bound_R3: assert property (@(posedge clk) disable iff (rst)
    int'(car_ramp) <= AMP);

  assert_ramp_step_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
      ((int'(car_ramp) - int'($past(car_ramp)) == STEP) ||
       (int'($past(car_ramp)) - int'(car_ramp) == STEP)));

  assert_thermo_R4: assert property (@(posedge clk) disable iff (rst)
    (below_vec & (below_vec + 1'b1)) == '0);
endmodule

bind ml_pwm_mod mlp_chk #(.AMP_LOG2(AMP_LOG2), .CAR_PERIOD(CAR_PERIOD)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .smp_vld   (smp_vld),
  .lvl       (lvl),
  .gate      (gate),
  .car_ramp  (car_ramp),
  .below_vec (below_vec)
);

// File: tb/ml_pwm_mod_tb.sv
`timescale 1ns/1ps
module ml_pwm_mod_tb;
  localparam int PER = 16;
  localparam int NV  = 18;
  // columns: mode, reference, ramp phase, expected level, requirement
  localparam int TV [NV][5] = '{
    '{0,     0,  0,  0, 5},   // R5 tie at band edge
    '{0,     1,  0,  1, 4},   // R4
    '{0,     1,  1,  0, 3},   // R3 ramp has moved
    '{0,   700,  4,  1, 6},   // R6
    '{0,   600,  0,  2, 4},   // R4
    '{0,  1536,  8,  2, 5},   // R5 tie at top peak
    '{0,  1537,  8,  3, 10},  // R10
    '{0, -1536,  0, -3, 10},  // R10
    '{1,  -200,  2, -1, 7},   // R7
    '{0,  -200,  2,  0, 6},   // R6
    '{2,   800,  2,  1, 8},   // R8
    '{1,   800,  2,  2, 7},   // R7
    '{3,  -200,  2,  0, 6},   // R6 mode 3
    '{2,  -500, 13, -1, 8},   // R8 falling slope (R3)
    '{2, -1000, 13, -2, 8},   // R8
    '{1, -1000, 13, -2, 7},   // R7
    '{1,  1300, 13,  3, 7},   // R7
    '{1, -1300, 13, -3, 7}    // R7
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              smp_vld = 1'b0;
  logic signed [11:0] ref_smp = '0;
  logic [1:0]        car_mode = '0;
  logic signed [2:0] lvl;
  logic [7:0]        gate;
  int total = 0;
  int bad = 0;
  int ecount = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) ecount <= 0;
    else     ecount <= ecount + 1;
  end

  ml_pwm_mod #(.REF_W(12), .AMP_LOG2(9), .CAR_PERIOD(PER)) u_dut (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .ref_smp(ref_smp),
    .car_mode(car_mode), .lvl(lvl), .gate(gate)
  );

  function automatic string rtag(input int r);
    case (r)
      3: return "R3";   4: return "R4";   5: return "R5";
      6: return "R6";   7: return "R7";   8: return "R8";
      default: return "R10";
    endcase
  endfunction

  // S1..S8 written left to right, then mapped to gate[0..7]
  function automatic logic [7:0] exp_gate(input int lv);
    logic [7:0] s;
    logic [7:0] g;
    case (lv)
      3:  s = 8'b00110110;
      2:  s = 8'b01010110;
      1:  s = 8'b00111010;
      -1: s = 8'b00111001;
      -2: s = 8'b01011001;
      -3: s = 8'b11001001;
      default: s = 8'b01011010;
    endcase
    for (int i = 0; i < 8; i++) g[i] = s[7-i];
    return g;
  endfunction

  task automatic check_out(input string tag, input int lv_exp);
    total++;
    if (int'(lvl) !== lv_exp) begin
      bad++;
      $display("FAIL %s level actual=%0d expected=%0d", tag, int'(lvl), lv_exp);
    end
    total++;
    if (gate !== exp_gate(lv_exp)) begin
      bad++;
      $display("FAIL R9 (%s) gate actual=%b expected=%b", tag, gate, exp_gate(lv_exp));
    end
    total++;
    if (!((gate[4] ^ gate[5]) && (gate[6] ^ gate[7]))) begin
      bad++;
      $display("FAIL R11 leg pair actual=%b expected=complementary", gate);
    end
  endtask

  task automatic apply_at(input int mode, input int rv, input int ph);
    @(negedge clk);
    while ((ecount % PER) != ph) @(negedge clk);
    car_mode = 2'(mode);
    ref_smp  = 12'(rv);
    smp_vld  = 1'b1;
    @(negedge clk);
    smp_vld  = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_out("R1 in reset", 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    ref_smp = 12'sd1000;
    @(negedge clk);
    check_out("R1 after reset", 0);

    for (int v = 0; v < NV; v++) begin
      apply_at(TV[v][0], TV[v][1], TV[v][2]);
      check_out(rtag(TV[v][4]), TV[v][3]);
    end

    // R2: no strobe, changing inputs, outputs hold at -3
    ref_smp  = 12'sd1500;
    car_mode = 2'd2;
    repeat (6) @(negedge clk);
    check_out("R2 hold", -3);

    // R2: strobe takes effect one cycle later
    apply_at(0, 2000, 5);
    check_out("R2 update", 3);

    // R1: reset mid-run returns to zero pattern
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_out("R1 mid-run reset", 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule